// File: doc/BRIEF.md
# I2C Master FIFO Watermark Data-Request and Interrupt Logic

This block decides, cycle by cycle, when an I2C master asks the host to move data through its FIFO, when the current command counts as finished, and whether the single interrupt pin is raised. It compares the FIFO occupancy with a high and a low watermark. It also tracks two residual byte counts: one for bytes still to cross the bus and one for bytes the host still has to move. From these it forms a data-request bit, a command-complete bit and two watermark flags. All four are re-evaluated only while the bus is busy and hold their value otherwise.

The status bits sit in the upper half of a 32-bit status word. The raw interrupt condition is that upper half. A 16-bit mask selects which raw bits reach the interrupt. The mask accepts three kinds of write: replace, OR-in and AND-away. When both residual counts are zero on a command that asked for a stop, the block requests the end of the bus transfer and drops its two transfer-busy flags.

Top module: `wm_irq_top`

## Requirements
- R1: After reset, dataReq is 0, cmdComp is 1, both watermark flags are 0, busyFlags is 2'b00, the mask is 0, endXfer is 0 and irq is 0.
- R2: In a cycle with busBusy low, dataReq, cmdComp, highWater, lowWater and endXfer keep their previous values at the next clock edge.
- R3: In a busy read cycle (isRead=1) with work left, highWater loads (fifoCount >= highMark). dataReq loads ((new highWater and fifoCount != 0) or frontRes == 0).
- R4: In a busy write cycle (isRead=0) with work left, lowWater loads (fifoCount <= lowMark). dataReq loads (backRes != 0 and (fifoSize - fifoCount >= backRes or new lowWater)).
- R5: A busy read cycle leaves lowWater unchanged, and a busy write cycle leaves highWater unchanged.
- R6: In a busy cycle with frontRes == 0 and backRes == 0, the next edge gives dataReq = 0 and cmdComp = 1.
- R7: In a busy cycle with frontRes or backRes nonzero, the next edge gives cmdComp = 0.
- R8: A busy completion cycle (R6) with stopReq = 1 sets endXfer and clears busyFlags at the next edge. Every other cycle loads endXfer = 0, and a completion without stop keeps busyFlags.
- R9: xferStart sets busyFlags to 2'b11 at the next edge. It takes priority over the clear of R8.
- R10: statusWord[31:16] equals rawCond and statusWord[15:0] is 0. dataReq sits at rawCond bit 4 (status bit 20) and cmdComp at rawCond bit 7 (status bit 23). The other raw bits are 0.
- R11: A mask write replaces the mask (maskWrEn), ORs maskWrData in (maskOrEn) or ANDs it in (maskAndEn), with priority maskWrEn over maskOrEn over maskAndEn.
- R12: maskedCond is rawCond AND mask. irq is registered and equals, after each edge, whether maskedCond was nonzero before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoCount | input | CNT_W | Current FIFO occupancy |
| fifoSize | input | CNT_W | FIFO capacity in entries |
| isRead | input | 1 | Direction of the active command, 1 = read |
| frontRes | input | LEN_W | Bytes still to cross the bus |
| backRes | input | LEN_W | Bytes the host still has to move |
| highMark | input | CNT_W | High watermark threshold |
| lowMark | input | CNT_W | Low watermark threshold |
| busBusy | input | 1 | Bus transfer in progress |
| stopReq | input | 1 | Active command asks for a stop |
| xferStart | input | 1 | Pulse: transfer started, sets busy flags |
| maskWrData | input | 16 | Data for mask writes |
| maskWrEn | input | 1 | Replace the mask |
| maskOrEn | input | 1 | OR data into the mask |
| maskAndEn | input | 1 | AND data into the mask |
| dataReq | output | 1 | Data-request status bit |
| cmdComp | output | 1 | Command-complete status bit |
| highWater | output | 1 | High watermark flag |
| lowWater | output | 1 | Low watermark flag |
| busyFlags | output | 2 | Bus-busy and engine-busy extended flags |
| statusWord | output | 32 | Status word, interrupt bits in the upper half |
| rawCond | output | 16 | Raw interrupt condition |
| maskedCond | output | 16 | Masked interrupt condition |
| maskValue | output | 16 | Current interrupt mask |
| endXfer | output | 1 | Request to end the bus transfer |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench targets the boundaries of the watermark compares: occupancy exactly equal to the high or the low threshold, free space exactly equal to the host residual, and an empty FIFO above a zero high threshold. A design with a strict compare, or one that skips the non-empty term, raises or drops dataReq on the wrong byte. It also covers a busy read with a zero bus residual, completion with and without stop, and an idle cycle with changed inputs. A design that re-evaluates while idle, or that ends the transfer without a stop, shows wrong status or busy flags. The mask tests apply all three write strobes together and watch irq for its one-cycle lag. A wrong priority or a combinational interrupt shows up at once on the pin.

// File: rtl/wm_pkg.sv
package wm_pkg;
  // Positions of the status bits inside the raw interrupt condition.
  localparam int DR_POS = 4;
  localparam int CC_POS = 7;
  localparam int RAW_W  = 16;

  // Compare results produced by the datapath.
  typedef struct packed {
    logic highHit;
    logic lowHit;
    logic notEmpty;
    logic freeCovers;
    logic frontZero;
    logic backZero;
  } wmCmp_t;

  // Strobes from control to the state registers.
  typedef struct packed {
    logic ldStat;
    logic ldHigh;
    logic ldLow;
    logic drNext;
    logic ccNext;
    logic endNext;
    logic dropBusy;
  } wmStrobe_t;
endpackage

// File: rtl/wm_compare.sv
module wm_compare
  import wm_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 16
) (
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] fifoSize,
  input  logic [LEN_W-1:0] frontRes,
  input  logic [LEN_W-1:0] backRes,
  input  logic [CNT_W-1:0] highMark,
  input  logic [CNT_W-1:0] lowMark,
  output wmCmp_t           cmp
);
  localparam int WIDE_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [CNT_W-1:0]  freeSlots;
  logic [WIDE_W-1:0] freeWide;
  logic [WIDE_W-1:0] backWide;

  // Free space saturates at zero if occupancy ever exceeds capacity.
  always_comb begin
    if (fifoCount > fifoSize) freeSlots = '0;
    else                      freeSlots = fifoSize - fifoCount;
  end

  assign freeWide = WIDE_W'(freeSlots);
  assign backWide = WIDE_W'(backRes);

  always_comb begin
    cmp.highHit    = (fifoCount >= highMark);
    cmp.lowHit     = (fifoCount <= lowMark);
    cmp.notEmpty   = (fifoCount != '0);
    cmp.freeCovers = (freeWide >= backWide);
    cmp.frontZero  = (frontRes == '0);
    cmp.backZero   = (backRes == '0);
  end
endmodule

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
(
  input  logic      busBusy,
  input  logic      isRead,
  input  logic      stopReq,
  input  wmCmp_t    cmp,
  output wmStrobe_t stb
);
  logic allDone;
  logic readReq;
  logic writeReq;

  assign allDone  = cmp.frontZero && cmp.backZero;
  // The watermark term uses the flag value being loaded this cycle.
  assign readReq  = (cmp.highHit && cmp.notEmpty) || cmp.frontZero;
  assign writeReq = !cmp.backZero && (cmp.freeCovers || cmp.lowHit);

  always_comb begin
    stb          = '0;
    stb.ldStat   = busBusy;
    stb.ldHigh   = busBusy && isRead;
    stb.ldLow    = busBusy && !isRead;
    if (allDone) begin
      stb.drNext = 1'b0;
      stb.ccNext = 1'b1;
    end else begin
      stb.drNext = isRead ? readReq : writeReq;
      stb.ccNext = 1'b0;
    end
    stb.endNext  = busBusy && allDone && stopReq;
    stb.dropBusy = busBusy && allDone && stopReq;
  end
endmodule

// File: rtl/wm_state.sv
module wm_state
  import wm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wmStrobe_t        stb,
  input  logic             highHit,
  input  logic             lowHit,
  input  logic             xferStart,
  input  logic [RAW_W-1:0] maskWrData,
  input  logic             maskWrEn,
  input  logic             maskOrEn,
  input  logic             maskAndEn,
  output logic             dataReq,
  output logic             cmdComp,
  output logic             highWater,
  output logic             lowWater,
  output logic [1:0]       busyFlags,
  output logic             endXfer,
  output logic [RAW_W-1:0] rawCond,
  output logic [RAW_W-1:0] maskedCond,
  output logic [RAW_W-1:0] maskValue,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReq   <= 1'b0;
      cmdComp   <= 1'b1;
      highWater <= 1'b0;
      lowWater  <= 1'b0;
      endXfer   <= 1'b0;
    end else begin
      if (stb.ldStat) begin
        dataReq <= stb.drNext;
        cmdComp <= stb.ccNext;
        endXfer <= stb.endNext;
      end
      if (stb.ldHigh) highWater <= highHit;
      if (stb.ldLow)  lowWater  <= lowHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busyFlags <= 2'b00;
    else if (xferStart)     busyFlags <= 2'b11;
    else if (stb.dropBusy)  busyFlags <= 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          maskValue <= '0;
    else if (maskWrEn)  maskValue <= maskWrData;
    else if (maskOrEn)  maskValue <= maskValue | maskWrData;
    else if (maskAndEn) maskValue <= maskValue & maskWrData;
  end

  always_comb begin
    rawCond         = '0;
    rawCond[DR_POS] = dataReq;
    rawCond[CC_POS] = cmdComp;
  end

  assign maskedCond = rawCond & maskValue;

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |maskedCond;
  end
endmodule

// File: rtl/wm_irq_top.sv
module wm_irq_top
  import wm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] fifoSize,
  input  logic             isRead,
  input  logic [LEN_W-1:0] frontRes,
  input  logic [LEN_W-1:0] backRes,
  input  logic [CNT_W-1:0] highMark,
  input  logic [CNT_W-1:0] lowMark,
  input  logic             busBusy,
  input  logic             stopReq,
  input  logic             xferStart,
  input  logic [15:0]      maskWrData,
  input  logic             maskWrEn,
  input  logic             maskOrEn,
  input  logic             maskAndEn,
  output logic             dataReq,
  output logic             cmdComp,
  output logic             highWater,
  output logic             lowWater,
  output logic [1:0]       busyFlags,
  output logic [31:0]      statusWord,
  output logic [15:0]      rawCond,
  output logic [15:0]      maskedCond,
  output logic [15:0]      maskValue,
  output logic             endXfer,
  output logic             irq
);
  wmCmp_t    cmp;
  wmStrobe_t stb;

  wm_compare #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cmp (
    .fifoCount(fifoCount), .fifoSize(fifoSize),
    .frontRes(frontRes),   .backRes(backRes),
    .highMark(highMark),   .lowMark(lowMark),
    .cmp(cmp)
  );

  wm_ctrl u_ctrl (
    .busBusy(busBusy), .isRead(isRead), .stopReq(stopReq),
    .cmp(cmp), .stb(stb)
  );

  wm_state u_state (
    .clk(clk), .rstN(rstN), .stb(stb),
    .highHit(cmp.highHit), .lowHit(cmp.lowHit),
    .xferStart(xferStart),
    .maskWrData(maskWrData), .maskWrEn(maskWrEn),
    .maskOrEn(maskOrEn), .maskAndEn(maskAndEn),
    .dataReq(dataReq), .cmdComp(cmdComp),
    .highWater(highWater), .lowWater(lowWater),
    .busyFlags(busyFlags), .endXfer(endXfer),
    .rawCond(rawCond), .maskedCond(maskedCond),
    .maskValue(maskValue), .irq(irq)
  );

  // Interrupt-capable bits live in the upper half of the status word.
  assign statusWord = {rawCond, 16'h0000};
endmodule

// File: rtl/wm_irq_chk.sv
module wm_irq_chk #(
  parameter int CNT_W = 4,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busBusy,
  input logic             isRead,
  input logic             stopReq,
  input logic [CNT_W-1:0] fifoCount,
  input logic [LEN_W-1:0] frontRes,
  input logic [LEN_W-1:0] backRes,
  input logic [15:0]      maskWrData,
  input logic             maskWrEn,
  input logic             maskOrEn,
  input logic             maskAndEn,
  input logic             dataReq,
  input logic             cmdComp,
  input logic             endXfer,
  input logic [1:0]       busyFlags,
  input logic [31:0]      statusWord,
  input logic [15:0]      rawCond,
  input logic [15:0]      maskedCond,
  input logic [15:0]      maskValue,
  input logic             irq
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |=> $stable(dataReq) && $stable(cmdComp));

  assert_write_nodr_R4: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && !isRead && backRes == '0 && frontRes != '0 |=> !dataReq);

  assert_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && frontRes == '0 && backRes == '0 |=> cmdComp && !dataReq);

  assert_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && (frontRes != '0 || backRes != '0) |=> !cmdComp);

  assert_stop_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    busBusy && frontRes == '0 && backRes == '0 && stopReq |=> endXfer);

  assert_raw_map_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[31:16] == rawCond) && ((rawCond & 16'hFF6F) == 16'h0000));

  assert_mask_or_R11: assert property (@(posedge clk) disable iff (!rstN)
    maskOrEn && !maskWrEn |=> (maskValue & $past(maskWrData)) == $past(maskWrData));

  assert_mask_and_R11: assert property (@(posedge clk) disable iff (!rstN)
    maskAndEn && !maskWrEn && !maskOrEn |=> (maskValue & ~$past(maskWrData)) == 16'h0000);

  assert_irq_lag_R12: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> irq == $past(|maskedCond));

  assert_masked_sub_R12: assert property (@(posedge clk) disable iff (!rstN)
    (maskedCond & ~rawCond) == 16'h0000);
endmodule

bind wm_irq_top wm_irq_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .busBusy(busBusy), .isRead(isRead),
  .stopReq(stopReq), .fifoCount(fifoCount), .frontRes(frontRes),
  .backRes(backRes), .maskWrData(maskWrData), .maskWrEn(maskWrEn),
  .maskOrEn(maskOrEn), .maskAndEn(maskAndEn), .dataReq(dataReq),
  .cmdComp(cmdComp), .endXfer(endXfer), .busyFlags(busyFlags),
  .statusWord(statusWord), .rawCond(rawCond), .maskedCond(maskedCond),
  .maskValue(maskValue), .irq(irq)
);

// File: tb/tb_wm_irq_top.sv
module tb_wm_irq_top;
  localparam int CNT_W = 4;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] fifoCount, fifoSize, highMark, lowMark;
  logic             isRead, busBusy, stopReq, xferStart;
  logic [LEN_W-1:0] frontRes, backRes;
  logic [15:0]      maskWrData;
  logic             maskWrEn, maskOrEn, maskAndEn;
  logic             dataReq, cmdComp, highWater, lowWater, endXfer, irq;
  logic [1:0]       busyFlags;
  logic [31:0]      statusWord;
  logic [15:0]      rawCond, maskedCond, maskValue;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic dr; logic cc; logic hw; logic lw; logic [1:0] bf;
    logic ex; logic irq; logic [15:0] mask;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  // Bench model state
  logic mDr, mCc, mHw, mLw, mEx, mIrq;
  logic [1:0]  mBf;
  logic [15:0] mMask;

  wm_irq_top #(.FIFO_DEPTH(8), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .fifoSize(fifoSize),
    .isRead(isRead), .frontRes(frontRes), .backRes(backRes),
    .highMark(highMark), .lowMark(lowMark), .busBusy(busBusy),
    .stopReq(stopReq), .xferStart(xferStart), .maskWrData(maskWrData),
    .maskWrEn(maskWrEn), .maskOrEn(maskOrEn), .maskAndEn(maskAndEn),
    .dataReq(dataReq), .cmdComp(cmdComp), .highWater(highWater),
    .lowWater(lowWater), .busyFlags(busyFlags), .statusWord(statusWord),
    .rawCond(rawCond), .maskedCond(maskedCond), .maskValue(maskValue),
    .endXfer(endXfer), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] rawOf(input logic dr, input logic cc);
    logic [15:0] r;
    r = 16'h0000;
    r[4] = dr;
    r[7] = cc;
    return r;
  endfunction

  task automatic checkBit(input string tag, input string name,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  // Monitor: pops one expected item per clock edge and compares.
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      expItem_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkBit(t, "dataReq",   32'(dataReq),   32'(e.dr));
      checkBit(t, "cmdComp",   32'(cmdComp),   32'(e.cc));
      checkBit(t, "highWater", 32'(highWater), 32'(e.hw));
      checkBit(t, "lowWater",  32'(lowWater),  32'(e.lw));
      checkBit(t, "busyFlags", 32'(busyFlags), 32'(e.bf));
      checkBit(t, "endXfer",   32'(endXfer),   32'(e.ex));
      checkBit(t, "irq",       32'(irq),       32'(e.irq));
      checkBit(t, "mask",      32'(maskValue), 32'(e.mask));
      // R10 layout and R12 masking, from the bench model
      checkBit({t, "/R10"}, "statusWord", statusWord, {rawOf(e.dr, e.cc), 16'h0000});
      checkBit({t, "/R12"}, "maskedCond", 32'(maskedCond), 32'(rawOf(e.dr, e.cc) & e.mask));
    end
  end

  // Driver: predict the next state from the current inputs, push it,
  // let one edge pass, then clear pulse inputs at the falling edge.
  task automatic step(input string tag);
    logic done, drS, hwN, lwN;
    logic [15:0] freeN;
    mIrq = |(rawOf(mDr, mCc) & mMask);
    if (maskWrEn)       mMask = maskWrData;
    else if (maskOrEn)  mMask = mMask | maskWrData;
    else if (maskAndEn) mMask = mMask & maskWrData;
    done = (frontRes == 0) && (backRes == 0);
    if (busBusy) begin
      hwN = (fifoCount >= highMark);
      lwN = (fifoCount <= lowMark);
      freeN = 16'(fifoSize) - 16'(fifoCount);
      if (isRead) begin
        mHw = hwN;
        drS = (hwN && fifoCount != 0) || (frontRes == 0);
      end else begin
        mLw = lwN;
        drS = (backRes != 0) && ((freeN >= backRes) || lwN);
      end
      if (done) begin mDr = 1'b0; mCc = 1'b1; end
      else      begin mDr = drS;  mCc = 1'b0; end
      mEx = done && stopReq;
    end
    if (xferStart)                     mBf = 2'b11;
    else if (busBusy && done && stopReq) mBf = 2'b00;
    expQ.push_back('{dr: mDr, cc: mCc, hw: mHw, lw: mLw, bf: mBf,
                     ex: mEx, irq: mIrq, mask: mMask});
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    xferStart = 0; maskWrEn = 0; maskOrEn = 0; maskAndEn = 0;
  endtask

  task automatic setRun(input logic rd, input int cnt, input int fr, input int bk);
    busBusy = 1; isRead = rd; fifoCount = CNT_W'(cnt);
    frontRes = LEN_W'(fr); backRes = LEN_W'(bk);
  endtask

  initial begin
    rstN = 0; fifoCount = 0; fifoSize = 8; highMark = 3; lowMark = 2;
    isRead = 0; frontRes = 0; backRes = 0; busBusy = 0; stopReq = 0;
    xferStart = 0; maskWrData = 0; maskWrEn = 0; maskOrEn = 0; maskAndEn = 0;
    mDr = 0; mCc = 1; mHw = 0; mLw = 0; mEx = 0; mIrq = 0; mBf = 2'b00; mMask = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset values hold through an idle cycle
    step("R1");
    // R11 plain write, R12: mask cmdComp -> irq one edge later
    maskWrData = 16'h0080; maskWrEn = 1; step("R11 plain");
    step("R12 irq lag");
    // R9: start sets the busy flags
    xferStart = 1; step("R9");
    // R3 read: count below high mark, then equal, then empty with zero mark
    setRun(1, 0, 4, 4); highMark = 3; step("R3 below/R7");
    setRun(1, 3, 4, 4); step("R3 equal high");
    highMark = 0; setRun(1, 0, 4, 4); step("R3 empty zero mark");
    highMark = 7; setRun(1, 2, 0, 2); step("R3 front zero");
    setRun(1, 8, 4, 4); highMark = 8; step("R3 full");
    // R2: idle with changed inputs holds everything
    busBusy = 0; fifoCount = 0; frontRes = 0; backRes = 0; step("R2 idle");
    // R4/R5 write path
    lowMark = 2; setRun(0, 6, 3, 3); step("R4 free short/R5");
    setRun(0, 5, 3, 3); step("R4 free exact");
    setRun(0, 3, 9, 9); step("R4 above low");
    setRun(0, 2, 9, 9); step("R4 at low");
    setRun(0, 1, 3, 0); step("R4 back zero");
    // R6 completion without stop keeps busy flags
    stopReq = 0; setRun(0, 0, 0, 0); step("R6 no stop/R8");
    setRun(1, 4, 2, 2); step("R7 pending");
    // R8 completion with stop
    stopReq = 1; setRun(1, 0, 0, 0); step("R8 stop");
    busBusy = 0; stopReq = 0; step("R2 end hold");
    // R9 priority over the R8 clear
    xferStart = 1; busBusy = 1; stopReq = 1; frontRes = 0; backRes = 0; step("R9 priority");
    busBusy = 0; stopReq = 0; step("R2");
    // R11: OR, AND, and all three strobes at once
    maskWrData = 16'h0010; maskOrEn = 1; step("R11 or");
    maskWrData = 16'h0010; maskAndEn = 1; step("R11 and");
    maskWrData = 16'h0090; maskOrEn = 1; maskAndEn = 1; step("R11 or over and");
    maskWrData = 16'h0003; maskWrEn = 1; maskOrEn = 1; maskAndEn = 1; step("R11 plain first");
    step("R12 irq drop");
    // R12: dataReq raises irq through the mask
    maskWrData = 16'h0010; maskWrEn = 1; setRun(1, 3, 4, 4); highMark = 2; step("R12 dr");
    busBusy = 0; step("R12 dr irq");
    step("R12 steady");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule